// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Tracking Table

This block is a shared, fully associative table that ranks contended code regions by how much thread waiting they cause. Cores report events tagged with a region identifier: a thread starts or stops waiting on a region, or a small core starts or stops executing that region itself. On every clock, each live record adds its current number of waiting threads to its waiting-cycle counter. The region with the largest counter is reported. A record whose counter passes a programmable threshold is flagged for acceleration and holds a fixed large-core context, chosen when the record was created.

A lookup port returns a region's record so that a calling core can decide whether to run the region locally or send it to its large-core context. When the top-ranked region is flagged for acceleration and is currently running on a small core, the block raises a preemption request that names the region and that core. When a new region needs space in a full table, the record with the fewest accumulated waiting cycles is evicted. A decay pulse halves every counter so that the ranking follows changes in program phase.

The table is purely per-cycle: there is no sequencing state beyond the records and a round-robin context pointer. Every output is a combinational function of the registered records and the lookup key.

Top module: `btt_table`

## Requirements
- R1: A wait-begin event (ev_op = 0) for an identifier that is not held allocates a record with waiters = 1 and count = 0. The record is placed in the lowest-numbered free slot. Events of any other kind for an identifier that is not held change nothing.
- R2: A wait-begin event for an identifier that is held raises its waiter count by one, saturating at the maximum. A wait-end event (ev_op = 1) lowers it by one and holds at zero.
- R3: On every cycle, each live record that was not allocated in that cycle adds its waiter count to its waiting-cycle counter.
- R4: When the table is full, a new identifier replaces the live record with the smallest counter. Among equal counters, the lowest slot is replaced.
- R5: A record's accelerate flag is registered together with its counter. The flag is 1 exactly when the new counter is strictly greater than cfg_thresh.
- R6: Each new record takes the large-core context from a pointer that starts at 0 after reset and advances by one per allocation, wrapping after NCTX-1. The context never changes while the record lives.
- R7: preempt_valid is 1 exactly when the top-ranked record is flagged for acceleration and marked as running locally. Run-start (ev_op = 2) sets that mark and records ev_core as the owner; run-stop (ev_op = 3) clears it. preempt_id and preempt_core give the record's identifier and owner.
- R8: In a cycle with decay_pulse high, each counter is first halved (rounded down) and then the waiter count is added.
- R9: Waiting-cycle counters saturate at all ones and never wrap.
- R10: When an event changes a record's waiter count, the sum for that same cycle uses the updated waiter count.
- R11: After reset, no record is live: q_hit, top_valid and preempt_valid are 0.
- R12: top_valid is 1 when any record is live. top_id and top_count give the live record with the largest counter, taking the lowest slot among equal counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_op | input | 2 | Event kind: 0 wait-begin, 1 wait-end, 2 run-start, 3 run-stop |
| ev_id | input | ID_W | Region identifier of the event |
| ev_core | input | CORE_W | Small core that issued a run-start |
| decay_pulse | input | 1 | Halve all counters this cycle |
| cfg_thresh | input | CNT_W | Acceleration threshold |
| q_id | input | ID_W | Lookup key |
| q_hit | output | 1 | Lookup key is held |
| q_waiters | output | WAIT_W | Waiter count of the looked-up record |
| q_count | output | CNT_W | Waiting-cycle counter of the looked-up record |
| q_accel | output | 1 | Looked-up record is flagged for acceleration |
| q_ctx | output | CTX_W | Large-core context bound to the looked-up record |
| top_valid | output | 1 | At least one live record |
| top_id | output | ID_W | Identifier with the largest counter |
| top_count | output | CNT_W | Largest counter |
| preempt_valid | output | 1 | Preemption request |
| preempt_id | output | ID_W | Region to preempt |
| preempt_core | output | CORE_W | Small core currently running it |

## Verification
The bench builds the table with 4 entries, 8-bit counters, 3-bit waiter counts and two contexts. With 4 entries, eviction happens after only a few allocations. An 8-bit counter reaches saturation within a few dozen cycles of heavy waiting. A 3-bit waiter count saturates after seven wait-begin events. The directed phases and a long random phase with a small set of identifiers therefore reach replacement ties, decay, threshold crossings and context wrap-around many times over.

// File: rtl/btt_pkg.sv
package btt_pkg;
    typedef enum logic [1:0] {
        OP_WAIT_BEGIN = 2'd0,
        OP_WAIT_END   = 2'd1,
        OP_RUN_START  = 2'd2,
        OP_RUN_STOP   = 2'd3
    } btt_op_e;
endpackage

// File: rtl/btt_entry.sv
module btt_entry #(
    parameter int ID_W   = 16,
    parameter int CNT_W  = 24,
    parameter int WAIT_W = 7,
    parameter int CORE_W = 6,
    parameter int CTX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_hit,
    input  logic [1:0]        ev_op,
    input  logic [CORE_W-1:0] ev_core,
    input  logic              decay,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              alloc,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [CTX_W-1:0]  alloc_ctx,
    output logic              valid,
    output logic [ID_W-1:0]   id,
    output logic [WAIT_W-1:0] waiters,
    output logic [CNT_W-1:0]  count,
    output logic              accel,
    output logic              run_local,
    output logic [CORE_W-1:0] owner,
    output logic [CTX_W-1:0]  ctx
);
    import btt_pkg::*;

    logic [WAIT_W-1:0] wait_nx;
    logic [CNT_W-1:0]  base;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  count_nx;

    // waiter update comes first, the accumulation uses its result
    always_comb begin
        wait_nx = waiters;
        if (ev_hit) begin
            if (ev_op == OP_WAIT_BEGIN && waiters != {WAIT_W{1'b1}})
                wait_nx = waiters + 1'b1;
            else if (ev_op == OP_WAIT_END && waiters != '0)
                wait_nx = waiters - 1'b1;
        end
        base     = decay ? (count >> 1) : count;
        sum      = {1'b0, base} + (CNT_W+1)'(wait_nx);
        count_nx = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            id        <= '0;
            waiters   <= '0;
            count     <= '0;
            accel     <= 1'b0;
            run_local <= 1'b0;
            owner     <= '0;
            ctx       <= '0;
        end else if (alloc) begin
            valid     <= 1'b1;
            id        <= alloc_id;
            waiters   <= WAIT_W'(1);
            count     <= '0;
            accel     <= 1'b0;
            run_local <= 1'b0;
            owner     <= '0;
            ctx       <= alloc_ctx;
        end else if (valid) begin
            waiters <= wait_nx;
            count   <= count_nx;
            accel   <= (count_nx > thresh);
            if (ev_hit && ev_op == OP_RUN_START) begin
                run_local <= 1'b1;
                owner     <= ev_core;
            end else if (ev_hit && ev_op == OP_RUN_STOP) begin
                run_local <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/btt_match.sv
module btt_match #(
    parameter int ENTRIES = 32,
    parameter int ID_W    = 16,
    parameter int CNT_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][ID_W-1:0]  ids,
    input  logic [ENTRIES-1:0][CNT_W-1:0] counts,
    input  logic [ID_W-1:0]               ev_key,
    input  logic [ID_W-1:0]               q_key,
    output logic [ENTRIES-1:0]            ev_match,
    output logic [ENTRIES-1:0]            q_match,
    output logic [IDX_W-1:0]              place_idx
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic             have_min;
    logic [IDX_W-1:0] min_idx;
    logic [CNT_W-1:0] min_cnt;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign ev_match[g] = valid[g] && (ids[g] == ev_key);
            assign q_match[g]  = valid[g] && (ids[g] == q_key);
        end
    endgenerate

    // lowest free slot first, otherwise the smallest counter
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        have_min  = 1'b0;
        min_idx   = '0;
        min_cnt   = '1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !have_free) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (valid[i] && (!have_min || counts[i] < min_cnt)) begin
                have_min = 1'b1;
                min_idx  = IDX_W'(i);
                min_cnt  = counts[i];
            end
        end
        place_idx = have_free ? free_idx : min_idx;
    end
endmodule

// File: rtl/btt_rank.sv
module btt_rank #(
    parameter int ENTRIES = 32,
    parameter int CNT_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][CNT_W-1:0] counts,
    output logic                          any_valid,
    output logic [IDX_W-1:0]              max_idx
);
    logic [CNT_W-1:0] max_cnt;

    always_comb begin
        any_valid = 1'b0;
        max_idx   = '0;
        max_cnt   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid[i] && (!any_valid || counts[i] > max_cnt)) begin
                any_valid = 1'b1;
                max_idx   = IDX_W'(i);
                max_cnt   = counts[i];
            end
        end
    end
endmodule

// File: rtl/btt_table.sv
module btt_table #(
    parameter int ENTRIES = 32,
    parameter int ID_W    = 16,
    parameter int CNT_W   = 24,
    parameter int WAIT_W  = 7,
    parameter int CORE_W  = 6,
    parameter int NCTX    = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_op,
    input  logic [ID_W-1:0]   ev_id,
    input  logic [CORE_W-1:0] ev_core,
    input  logic              decay_pulse,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [ID_W-1:0]   q_id,
    output logic              q_hit,
    output logic [WAIT_W-1:0] q_waiters,
    output logic [CNT_W-1:0]  q_count,
    output logic              q_accel,
    output logic [CTX_W-1:0]  q_ctx,
    output logic              top_valid,
    output logic [ID_W-1:0]   top_id,
    output logic [CNT_W-1:0]  top_count,
    output logic              preempt_valid,
    output logic [ID_W-1:0]   preempt_id,
    output logic [CORE_W-1:0] preempt_core
);
    import btt_pkg::*;

    logic [ENTRIES-1:0]             e_valid;
    logic [ENTRIES-1:0][ID_W-1:0]   e_id;
    logic [ENTRIES-1:0][WAIT_W-1:0] e_wait;
    logic [ENTRIES-1:0][CNT_W-1:0]  e_cnt;
    logic [ENTRIES-1:0]             e_accel;
    logic [ENTRIES-1:0]             e_local;
    logic [ENTRIES-1:0][CORE_W-1:0] e_owner;
    logic [ENTRIES-1:0][CTX_W-1:0]  e_ctx;

    logic [ENTRIES-1:0] ev_match;
    logic [ENTRIES-1:0] q_match;
    logic [IDX_W-1:0]   place_idx;
    logic [IDX_W-1:0]   top_idx;
    logic               do_alloc;
    logic [CTX_W-1:0]   ctx_ptr;

    assign do_alloc = ev_valid && (ev_op == OP_WAIT_BEGIN) && (ev_match == '0);

    btt_match #(.ENTRIES(ENTRIES), .ID_W(ID_W), .CNT_W(CNT_W)) match_i (
        .valid     (e_valid),
        .ids       (e_id),
        .counts    (e_cnt),
        .ev_key    (ev_id),
        .q_key     (q_id),
        .ev_match  (ev_match),
        .q_match   (q_match),
        .place_idx (place_idx)
    );

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            btt_entry #(
                .ID_W(ID_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W),
                .CORE_W(CORE_W), .CTX_W(CTX_W)
            ) ent_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .ev_hit    (ev_valid && ev_match[g]),
                .ev_op     (ev_op),
                .ev_core   (ev_core),
                .decay     (decay_pulse),
                .thresh    (cfg_thresh),
                .alloc     (do_alloc && (place_idx == IDX_W'(g))),
                .alloc_id  (ev_id),
                .alloc_ctx (ctx_ptr),
                .valid     (e_valid[g]),
                .id        (e_id[g]),
                .waiters   (e_wait[g]),
                .count     (e_cnt[g]),
                .accel     (e_accel[g]),
                .run_local (e_local[g]),
                .owner     (e_owner[g]),
                .ctx       (e_ctx[g])
            );
        end
    endgenerate

    // round-robin binding of new records to large-core contexts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctx_ptr <= '0;
        else if (do_alloc)
            ctx_ptr <= (ctx_ptr == CTX_W'(NCTX-1)) ? '0 : ctx_ptr + 1'b1;
    end

    btt_rank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) rank_i (
        .valid     (e_valid),
        .counts    (e_cnt),
        .any_valid (top_valid),
        .max_idx   (top_idx)
    );

    always_comb begin
        q_hit     = 1'b0;
        q_waiters = '0;
        q_count   = '0;
        q_accel   = 1'b0;
        q_ctx     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (q_match[i]) begin
                q_hit     = 1'b1;
                q_waiters = e_wait[i];
                q_count   = e_cnt[i];
                q_accel   = e_accel[i];
                q_ctx     = e_ctx[i];
            end
        end
    end

    assign top_id        = e_id[top_idx];
    assign top_count     = e_cnt[top_idx];
    assign preempt_valid = top_valid && e_accel[top_idx] && e_local[top_idx];
    assign preempt_id    = e_id[top_idx];
    assign preempt_core  = e_owner[top_idx];
endmodule

// File: rtl/btt_table_chk.sv
module btt_table_chk #(
    parameter int ID_W   = 16,
    parameter int CNT_W  = 24,
    parameter int WAIT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [1:0]        ev_op,
    input logic [ID_W-1:0]   ev_id,
    input logic              decay_pulse,
    input logic [ID_W-1:0]   q_id,
    input logic              q_hit,
    input logic [WAIT_W-1:0] q_waiters,
    input logic [CNT_W-1:0]  q_count,
    input logic              top_valid,
    input logic [ID_W-1:0]   top_id,
    input logic [CNT_W-1:0]  top_count,
    input logic              preempt_valid,
    input logic [ID_W-1:0]   preempt_id
);
    // R1: a wait-begin leaves the identifier held in the next cycle
    a_r1_alloc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ev_valid) && $past(ev_op) == 2'd0 && $past(ev_id) == q_id && $stable(q_id))
        |-> q_hit);

    // R2: wait-end lowers the waiter count and holds at zero
    a_r2_end_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ev_valid) && $past(ev_op) == 2'd1 && $past(ev_id) == q_id &&
         $stable(q_id) && $past(q_hit) && q_hit)
        |-> (q_waiters == (($past(q_waiters) == '0) ? '0 : $past(q_waiters) - 1'b1)));

    // R3: without decay or an event for it, a record's counter never shrinks
    a_r3_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_hit) && q_hit && $stable(q_id) && !$past(decay_pulse) &&
         !($past(ev_valid) && $past(ev_id) == q_id))
        |-> (q_count >= $past(q_count)));

    // R12: no held record exceeds the reported maximum
    a_r12_top_max: assert property (@(posedge clk) disable iff (!rst_n)
        q_hit |-> (top_valid && q_count <= top_count));

    // R7: a preemption request names the top-ranked record
    a_r7_preempt_top: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_valid |-> (top_valid && preempt_id == top_id));
endmodule

bind btt_table btt_table_chk #(.ID_W(ID_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid      (ev_valid),
    .ev_op         (ev_op),
    .ev_id         (ev_id),
    .decay_pulse   (decay_pulse),
    .q_id          (q_id),
    .q_hit         (q_hit),
    .q_waiters     (q_waiters),
    .q_count       (q_count),
    .top_valid     (top_valid),
    .top_id        (top_id),
    .top_count     (top_count),
    .preempt_valid (preempt_valid),
    .preempt_id    (preempt_id)
);

// File: tb/btt_table_tb.sv
`timescale 1ns/100ps
module btt_table_tb_top;
    localparam int N    = 4;
    localparam int IDW  = 8;
    localparam int CW   = 8;
    localparam int WW   = 3;
    localparam int CRW  = 4;
    localparam int NC   = 2;
    localparam int CMAX = (1 << CW) - 1;
    localparam int WMAX = (1 << WW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ev_valid = 1'b0;
    logic [1:0]     ev_op = 2'd0;
    logic [IDW-1:0] ev_id = '0;
    logic [CRW-1:0] ev_core = '0;
    logic           decay_pulse = 1'b0;
    logic [CW-1:0]  cfg_thresh = 8'd200;
    logic [IDW-1:0] q_id = '0;
    logic           q_hit;
    logic [WW-1:0]  q_waiters;
    logic [CW-1:0]  q_count;
    logic           q_accel;
    logic [0:0]     q_ctx;
    logic           top_valid;
    logic [IDW-1:0] top_id;
    logic [CW-1:0]  top_count;
    logic           preempt_valid;
    logic [IDW-1:0] preempt_id;
    logic [CRW-1:0] preempt_core;

    always #2.5 clk = ~clk;

    btt_table #(.ENTRIES(N), .ID_W(IDW), .CNT_W(CW), .WAIT_W(WW),
                .CORE_W(CRW), .NCTX(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op),
        .ev_id(ev_id), .ev_core(ev_core), .decay_pulse(decay_pulse),
        .cfg_thresh(cfg_thresh), .q_id(q_id), .q_hit(q_hit),
        .q_waiters(q_waiters), .q_count(q_count), .q_accel(q_accel),
        .q_ctx(q_ctx), .top_valid(top_valid), .top_id(top_id),
        .top_count(top_count), .preempt_valid(preempt_valid),
        .preempt_id(preempt_id), .preempt_core(preempt_core)
    );

    // behavioural reference: one record per slot
    int  m_v[N], m_id[N], m_w[N], m_c[N], m_a[N], m_l[N], m_o[N], m_x[N];
    int  m_rr;
    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;
    string tag = "R11";

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", req, tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_id[i] = 0; m_w[i] = 0; m_c[i] = 0;
            m_a[i] = 0; m_l[i] = 0; m_o[i] = 0; m_x[i] = 0;
        end
        m_rr = 0;
    endtask

    task automatic model_step(input bit v, input int op, input int id, input int core,
                              input bit dec, input int thr);
        int h = -1;
        int slot = -1;
        for (int i = 0; i < N; i++) if (m_v[i] != 0 && m_id[i] == id) h = i;
        if (v && op == 0 && h < 0) begin
            for (int i = 0; i < N; i++) if (m_v[i] == 0 && slot < 0) slot = i;
            if (slot < 0) begin
                slot = 0;
                for (int i = 1; i < N; i++) if (m_c[i] < m_c[slot]) slot = i;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (m_v[i] != 0) begin
                int nw = m_w[i];
                int nc;
                if (v && h == i && op == 0 && nw < WMAX) nw++;
                if (v && h == i && op == 1 && nw > 0) nw--;
                nc = (dec ? m_c[i] / 2 : m_c[i]) + nw;
                if (nc > CMAX) nc = CMAX;
                m_w[i] = nw; m_c[i] = nc; m_a[i] = (nc > thr) ? 1 : 0;
                if (v && h == i && op == 2) begin m_l[i] = 1; m_o[i] = core; end
                if (v && h == i && op == 3) m_l[i] = 0;
            end
        end
        if (slot >= 0) begin
            m_v[slot] = 1; m_id[slot] = id; m_w[slot] = 1; m_c[slot] = 0;
            m_a[slot] = 0; m_l[slot] = 0; m_o[slot] = 0; m_x[slot] = m_rr;
            m_rr = (m_rr + 1) % NC;
        end
    endtask

    task automatic compare();
        int h = -1;
        int t = -1;
        for (int i = 0; i < N; i++) if (m_v[i] != 0 && m_id[i] == int'(q_id)) h = i;
        for (int i = 0; i < N; i++) if (m_v[i] != 0 && (t < 0 || m_c[i] > m_c[t])) t = i;
        chk("R1 q_hit", int'(q_hit), (h >= 0) ? 1 : 0);
        if (h >= 0) begin
            chk("R2 q_waiters", int'(q_waiters), m_w[h]);
            chk("R3 q_count", int'(q_count), m_c[h]);
            chk("R5 q_accel", int'(q_accel), m_a[h]);
            chk("R6 q_ctx", int'(q_ctx), m_x[h]);
        end
        chk("R12 top_valid", int'(top_valid), (t >= 0) ? 1 : 0);
        if (t >= 0) begin
            chk("R12 top_id", int'(top_id), m_id[t]);
            chk("R12 top_count", int'(top_count), m_c[t]);
            chk("R7 preempt_valid", int'(preempt_valid), (m_a[t] != 0 && m_l[t] != 0) ? 1 : 0);
            if (m_a[t] != 0 && m_l[t] != 0) begin
                chk("R7 preempt_id", int'(preempt_id), m_id[t]);
                chk("R7 preempt_core", int'(preempt_core), m_o[t]);
            end
        end else begin
            chk("R11 preempt_valid", int'(preempt_valid), 0);
        end
    endtask

    task automatic step(input bit v, input int op, input int id, input int core, input bit dec);
        @(negedge clk);
        ev_valid = v; ev_op = 2'(op); ev_id = IDW'(id); ev_core = CRW'(core);
        decay_pulse = dec;
        @(posedge clk);
        #1;
        model_step(v, op, id, core, dec, int'(cfg_thresh));
        compare();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 1'b0);
    endtask

    initial begin
        model_reset();
        #12;
        tag = "R11";
        chk("R11 q_hit", int'(q_hit), 0);
        chk("R11 top_valid", int'(top_valid), 0);
        chk("R11 preempt_valid", int'(preempt_valid), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1, R3: first wait allocates, then one cycle per waiter
        tag = "R1"; q_id = 8'h45;
        step(1'b1, 0, 8'h45, 0, 1'b0);
        idle(3);
        // R10: second waiter counted in its own cycle
        tag = "R10";
        step(1'b1, 0, 8'h45, 0, 1'b0);
        idle(3);
        // R2: wait-end saturates at zero; ignored kinds on a miss
        tag = "R2";
        step(1'b1, 1, 8'h45, 0, 1'b0);
        step(1'b1, 1, 8'h45, 0, 1'b0);
        step(1'b1, 1, 8'h45, 0, 1'b0);
        q_id = 8'h99;
        step(1'b1, 1, 8'h99, 0, 1'b0);
        step(1'b1, 2, 8'h99, 3, 1'b0);
        idle(2);
        // R6, R4: fill, then replace the smallest counter
        tag = "R6";
        q_id = 8'h10; step(1'b1, 0, 8'h10, 0, 1'b0);
        q_id = 8'h20; step(1'b1, 0, 8'h20, 0, 1'b0);
        q_id = 8'h30; step(1'b1, 0, 8'h30, 0, 1'b0);
        idle(2);
        tag = "R4";
        step(1'b1, 1, 8'h30, 0, 1'b0);
        q_id = 8'h50; step(1'b1, 0, 8'h50, 0, 1'b0);
        q_id = 8'h30; idle(1);
        q_id = 8'h50; idle(2);
        // R5, R7: threshold and preemption of a locally running region
        tag = "R5";
        cfg_thresh = 8'd20;
        step(1'b1, 0, 8'h10, 0, 1'b0);
        step(1'b1, 0, 8'h10, 0, 1'b0);
        q_id = 8'h10; idle(6);
        tag = "R7";
        step(1'b1, 2, 8'h10, 5, 1'b0);
        idle(3);
        step(1'b1, 3, 8'h10, 0, 1'b0);
        idle(2);
        step(1'b1, 2, 8'h10, 9, 1'b0);
        idle(2);
        // R8: halving, alone and together with accumulation
        tag = "R8";
        step(1'b0, 0, 0, 0, 1'b1);
        idle(1);
        step(1'b1, 0, 8'h10, 0, 1'b1);
        idle(2);
        // R9: saturation of waiters and counter
        tag = "R9";
        for (int k = 0; k < 9; k++) step(1'b1, 0, 8'h10, 0, 1'b0);
        idle(40);
        // mixed random traffic over a small identifier set
        tag = "RND";
        cfg_thresh = 8'd60;
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 9));
            q_id = IDW'($urandom_range(1, 6));
            if (k % 200 == 150) cfg_thresh = 8'($urandom_range(0, 255));
            step(r < 8, int'($urandom_range(0, 3)), int'($urandom_range(1, 6)),
                 int'($urandom_range(0, 15)), (k % 37) == 36);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule